// File: doc/BRIEF.md
# Double-Buffered Channel Register Bank with Power Control

This block keeps the configuration state of a four-channel output device. A serial front end, not part of this block, decodes each completed command word and presents it here as a one-cycle write strobe together with its fields. A word either targets one channel's 8-bit code or carries the shared control fields: a buffering-mode flag, four range selects, four per-channel shutdown-inhibit bits and a global software activate bit. The block also receives the front end's synchronized enable level, a one-cycle pulse marking that level's falling edge, and a raw hardware activate pin.

Every register exists twice. Writes land in a pending copy. In double-buffered mode, the enable falling edge copies all pending codes and control fields into the live copy at once, so several channels change on the same cycle. In single-buffered mode, each word moves straight into the live copy and the enable edge is ignored. The mode flag has no pending copy. Once set it stays set until power-on reset. Each channel's enable flag combines its live inhibit bit, the live software activate bit and the synchronized hardware pin.

Top module: `chan_cfg_bank`

## Requirements
- R1: While `rst_n` is 0 and after it is released, every live code is 0x00, `rng_o` is 4'b1111 (1 means x2 range), `ch_on_o` is 4'b0000 and `mode_o` is 0. All pending copies take the same values.
- R2: While `mode_o` is 0, an accepted write changes only the pending copy. `code_o` and `rng_o` keep their values until a cycle with `en_fall` high.
- R3: While `mode_o` is 0, `en_fall` copies every pending code, range bit, inhibit bit and the activate bit into the live copy, visible the cycle after the pulse. Several words written before one pulse all appear on that same cycle. Channel c occupies `code_o[8c+7:8c]`, and `wr_ch` = c selects channel c.
- R4: If `wr_stb` and `en_fall` are high in the same cycle, the transfer takes the pending contents from before that write. The new word stays pending until the next `en_fall`.
- R5: A control word (`wr_is_ctrl` = 1) with `wr_mode` = 1 sets `mode_o` the cycle after the strobe, with no enable edge. The word's other fields follow the buffering that was in force when it was written.
- R6: While `mode_o` is 1, each accepted word reaches the live outputs the cycle after its strobe. `en_fall` then transfers nothing, so words left pending from double-buffered operation do not appear.
- R7: Once `mode_o` is 1, a control word with `wr_mode` = 0 leaves it at 1. Only reset clears it.
- R8: A write is accepted only when `en_lvl` is 1. A strobe while `en_lvl` is 0 changes neither the pending nor the live copy.
- R9: Channel c is on (`ch_on_o[c]` = 1) when its live inhibit bit is 1, or when the live activate bit and the synchronized hardware pin are both 1. A pending activate bit has no effect until it is transferred.
- R10: `hw_act_pin` passes through two flip-flops. A change on the pin reaches `ch_on_o` after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_stb | input | 1 | One-cycle strobe for a completed command word |
| wr_is_ctrl | input | 1 | 1 = control word, 0 = channel code word |
| wr_ch | input | 2 | Target channel of a code word |
| wr_code | input | 8 | Channel code, unsigned |
| wr_mode | input | 1 | Control: 1 requests single-buffered mode |
| wr_rng | input | 4 | Control: range per channel, 1 = x2, 0 = x1 |
| wr_inh | input | 4 | Control: per-channel shutdown inhibit |
| wr_act | input | 1 | Control: global software activate |
| en_lvl | input | 1 | Synchronized enable level from the front end |
| en_fall | input | 1 | One-cycle pulse on the enable falling edge |
| hw_act_pin | input | 1 | Asynchronous hardware activate pin |
| code_o | output | 32 | Live codes, channel c at bits 8c+7:8c |
| rng_o | output | 4 | Live range selects |
| ch_on_o | output | 4 | Per-channel active flags, 0 = shutdown |
| mode_o | output | 1 | Current buffering mode, 1 = single-buffered |

## Verification
A word strobe and an enable falling edge can arrive in the same cycle. That is the case where a wrong design would either lose the new word or release it early. The bench first leaves one channel's word pending, then drives a second channel's word together with `en_fall`. After that edge the first word must be live and the second must not. After the following pulse the second word must be live. The same kind of overlap on the control word, where a mode change and buffered fields share one word, is judged by checking that `mode_o` rises at once while the range and inhibit outputs wait.

// File: rtl/chan_cfg_pkg.sv
package chan_cfg_pkg;

   typedef enum logic {
      BUF_DOUBLE = 1'b0,
      BUF_SINGLE = 1'b1
   } buf_mode_e;

   localparam logic RNG_X2    = 1'b1;
   localparam logic INH_RESET = 1'b0;
   localparam logic ACT_RESET = 1'b0;

endpackage

// File: rtl/chan_cfg_sync.sv
module chan_cfg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= (sh_q << 1) | STAGES'(d_i);
         end
         assign q_o = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/chan_cfg_stage.sv
module chan_cfg_stage
   import chan_cfg_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CODE_W = 8,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_acc_i,
   input  logic                     wr_ctrl_i,
   input  logic [CH_W-1:0]          wr_ch_i,
   input  logic [CODE_W-1:0]        wr_code_i,
   input  logic [NUM_CH-1:0]        wr_rng_i,
   input  logic [NUM_CH-1:0]        wr_inh_i,
   input  logic                     wr_act_i,
   input  logic                     xfer_i,
   input  logic                     direct_i,
   output logic [NUM_CH*CODE_W-1:0] pend_codes_o,
   output logic [NUM_CH*CODE_W-1:0] live_codes_o,
   output logic [NUM_CH-1:0]        live_rng_o,
   output logic [NUM_CH-1:0]        live_inh_o,
   output logic                     live_act_o
);

   logic code_wr;
   logic ctrl_wr;

   assign code_wr = wr_acc_i & ~wr_ctrl_i;
   assign ctrl_wr = wr_acc_i &  wr_ctrl_i;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic [CODE_W-1:0] pend_q;
         logic [CODE_W-1:0] live_q;
         logic              hit;

         assign hit = code_wr && (wr_ch_i == CH_W'(c));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q <= '0;
               live_q <= '0;
            end else begin
               if (hit) pend_q <= wr_code_i;
               if (xfer_i)              live_q <= pend_q;
               else if (direct_i && hit) live_q <= wr_code_i;
            end
         end

         assign pend_codes_o[c*CODE_W +: CODE_W] = pend_q;
         assign live_codes_o[c*CODE_W +: CODE_W] = live_q;
      end
   endgenerate

   logic [NUM_CH-1:0] pend_rng_q, pend_inh_q;
   logic              pend_act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_rng_q <= {NUM_CH{RNG_X2}};
         pend_inh_q <= {NUM_CH{INH_RESET}};
         pend_act_q <= ACT_RESET;
         live_rng_o <= {NUM_CH{RNG_X2}};
         live_inh_o <= {NUM_CH{INH_RESET}};
         live_act_o <= ACT_RESET;
      end else begin
         if (ctrl_wr) begin
            pend_rng_q <= wr_rng_i;
            pend_inh_q <= wr_inh_i;
            pend_act_q <= wr_act_i;
         end
         if (xfer_i) begin
            live_rng_o <= pend_rng_q;
            live_inh_o <= pend_inh_q;
            live_act_o <= pend_act_q;
         end else if (direct_i && ctrl_wr) begin
            live_rng_o <= wr_rng_i;
            live_inh_o <= wr_inh_i;
            live_act_o <= wr_act_i;
         end
      end
   end

endmodule

// File: rtl/chan_cfg_power.sv
module chan_cfg_power #(
   parameter int NUM_CH = 4
) (
   input  logic [NUM_CH-1:0] inh_i,
   input  logic              act_i,
   input  logic              hw_i,
   output logic [NUM_CH-1:0] on_o
);

   logic grp_on;

   assign grp_on = act_i & hw_i;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_on
         assign on_o[c] = inh_i[c] | grp_on;
      end
   endgenerate

endmodule

// File: rtl/chan_cfg_bank.sv
module chan_cfg_bank
   import chan_cfg_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int CODE_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int CH_W       = $clog2(NUM_CH),
   localparam int BUS_W      = NUM_CH * CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic              wr_is_ctrl,
   input  logic [CH_W-1:0]   wr_ch,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              wr_mode,
   input  logic [NUM_CH-1:0] wr_rng,
   input  logic [NUM_CH-1:0] wr_inh,
   input  logic              wr_act,
   input  logic              en_lvl,
   input  logic              en_fall,
   input  logic              hw_act_pin,
   output logic [BUS_W-1:0]  code_o,
   output logic [NUM_CH-1:0] rng_o,
   output logic [NUM_CH-1:0] ch_on_o,
   output logic              mode_o
);

   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("chan_cfg_bank: NUM_CH must be at least 2");
      end
      if (CODE_W < 1) begin : g_bad_w
         $error("chan_cfg_bank: CODE_W must be positive");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("chan_cfg_bank: SYNC_STAGES must not be negative");
      end
   endgenerate

   buf_mode_e         mode_q;
   logic              wr_acc;
   logic              xfer;
   logic              hw_sync;
   logic [BUS_W-1:0]  pend_codes;
   logic [NUM_CH-1:0] live_inh;
   logic              live_act;

   assign wr_acc = wr_stb & en_lvl;
   assign xfer   = en_fall & (mode_q == BUF_DOUBLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= BUF_DOUBLE;
      else if (wr_acc && wr_is_ctrl && wr_mode)
         mode_q <= BUF_SINGLE;
   end

   assign mode_o = (mode_q == BUF_SINGLE);

   chan_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (hw_act_pin),
      .q_o   (hw_sync)
   );

   chan_cfg_stage #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_stage (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_acc_i     (wr_acc),
      .wr_ctrl_i    (wr_is_ctrl),
      .wr_ch_i      (wr_ch),
      .wr_code_i    (wr_code),
      .wr_rng_i     (wr_rng),
      .wr_inh_i     (wr_inh),
      .wr_act_i     (wr_act),
      .xfer_i       (xfer),
      .direct_i     (mode_q == BUF_SINGLE),
      .pend_codes_o (pend_codes),
      .live_codes_o (code_o),
      .live_rng_o   (rng_o),
      .live_inh_o   (live_inh),
      .live_act_o   (live_act)
   );

   chan_cfg_power #(.NUM_CH(NUM_CH)) u_power (
      .inh_i (live_inh),
      .act_i (live_act),
      .hw_i  (hw_sync),
      .on_o  (ch_on_o)
   );

endmodule

// File: rtl/chan_cfg_chk.sv
module chan_cfg_chk #(
   parameter int NUM_CH = 4,
   parameter int CODE_W = 8,
   localparam int CH_W  = $clog2(NUM_CH),
   localparam int BUS_W = NUM_CH * CODE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic              wr_is_ctrl,
   input logic [CH_W-1:0]   wr_ch,
   input logic [CODE_W-1:0] wr_code,
   input logic              wr_mode,
   input logic              en_lvl,
   input logic              en_fall,
   input logic [BUS_W-1:0]  code_o,
   input logic [NUM_CH-1:0] rng_o,
   input logic [NUM_CH-1:0] ch_on_o,
   input logic              mode_o,
   input logic [BUS_W-1:0]  pend_codes,
   input logic [NUM_CH-1:0] live_inh,
   input logic              live_act
);

   p_dbuf_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_o && !en_fall) |=> ($stable(code_o) && $stable(rng_o)));

   p_grp_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_o && en_fall) |=> (code_o == $past(pend_codes)));

   p_mode_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && en_lvl && wr_is_ctrl && wr_mode) |=> mode_o);

   p_mode_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o |=> mode_o);

   p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_lvl && !en_fall) |=> ($stable(pend_codes) && $stable(code_o)));

   p_inh_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((live_inh & ~ch_on_o) == '0));

   p_no_act_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !live_act |-> (ch_on_o == live_inh));

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_direct
         p_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_o && wr_stb && en_lvl && !wr_is_ctrl && wr_ch == CH_W'(c))
            |=> (code_o[c*CODE_W +: CODE_W] == $past(wr_code)));
      end
   endgenerate

endmodule

bind chan_cfg_bank chan_cfg_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_stb     (wr_stb),
   .wr_is_ctrl (wr_is_ctrl),
   .wr_ch      (wr_ch),
   .wr_code    (wr_code),
   .wr_mode    (wr_mode),
   .en_lvl     (en_lvl),
   .en_fall    (en_fall),
   .code_o     (code_o),
   .rng_o      (rng_o),
   .ch_on_o    (ch_on_o),
   .mode_o     (mode_o),
   .pend_codes (pend_codes),
   .live_inh   (live_inh),
   .live_act   (live_act)
);

// File: tb/test_chan_cfg_bank.sv
module test_chan_cfg_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0, wr_is_ctrl = 1'b0, wr_mode = 1'b0, wr_act = 1'b0;
   logic [1:0]  wr_ch = '0;
   logic [7:0]  wr_code = '0;
   logic [3:0]  wr_rng = '0, wr_inh = '0;
   logic        en_lvl = 1'b1, en_fall = 1'b0, hw_act_pin = 1'b0;
   logic [31:0] code_o;
   logic [3:0]  rng_o, ch_on_o;
   logic        mode_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [7:0] exp_pend [4];
   logic [7:0] exp_live [4];

   always #2 clk = ~clk;

   chan_cfg_bank i_chan_cfg_bank (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_is_ctrl(wr_is_ctrl),
      .wr_ch(wr_ch), .wr_code(wr_code), .wr_mode(wr_mode), .wr_rng(wr_rng),
      .wr_inh(wr_inh), .wr_act(wr_act), .en_lvl(en_lvl), .en_fall(en_fall),
      .hw_act_pin(hw_act_pin), .code_o(code_o), .rng_o(rng_o),
      .ch_on_o(ch_on_o), .mode_o(mode_o)
   );

   // {channel, code}: double-buffered writes, a transfer after every second one
   localparam logic [9:0] VEC [6] = '{
      {2'd0, 8'h12}, {2'd1, 8'h34}, {2'd2, 8'hFF},
      {2'd3, 8'h80}, {2'd0, 8'h01}, {2'd2, 8'h00}
   };

   function automatic logic [31:0] live_bus();
      return {exp_live[3], exp_live[2], exp_live[1], exp_live[0]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_dac(input logic [1:0] ch, input logic [7:0] code, input logic fall);
      @(negedge clk);
      wr_stb = 1'b1; wr_is_ctrl = 1'b0; wr_ch = ch; wr_code = code; en_fall = fall;
      @(negedge clk);
      wr_stb = 1'b0; en_fall = 1'b0;
      if (en_lvl) exp_pend[ch] = code;
   endtask

   task automatic wr_ctl(input logic md, input logic [3:0] rng, input logic [3:0] inh,
                         input logic a);
      @(negedge clk);
      wr_stb = 1'b1; wr_is_ctrl = 1'b1; wr_mode = md; wr_rng = rng; wr_inh = inh;
      wr_act = a;
      @(negedge clk);
      wr_stb = 1'b0; wr_is_ctrl = 1'b0; wr_mode = 1'b0;
   endtask

   task automatic pulse_fall();
      @(negedge clk);
      en_fall = 1'b1;
      @(negedge clk);
      en_fall = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 4; c++) begin exp_pend[c] = 8'h00; exp_live[c] = 8'h00; end

      // R1: reset state, during and after reset
      repeat (3) @(negedge clk);
      chk("R1 code in reset", code_o, 32'h0);
      chk("R1 range in reset", {28'h0, rng_o}, 32'hF);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 code after reset", code_o, 32'h0);
      chk("R1 range after reset", {28'h0, rng_o}, 32'hF);
      chk("R1 enables after reset", {28'h0, ch_on_o}, 32'h0);
      chk("R1 mode after reset", {31'h0, mode_o}, 32'h0);

      // R2 / R3: table walk in double-buffered mode
      for (int i = 0; i < 6; i++) begin
         wr_dac(VEC[i][9:8], VEC[i][7:0], 1'b0);
         chk("R2 live code held before edge", code_o, live_bus());
         if (i % 2 == 1) begin
            pulse_fall();
            for (int c = 0; c < 4; c++) exp_live[c] = exp_pend[c];
            chk("R3 group transfer on edge", code_o, live_bus());
         end
      end

      // R2 / R3 / R9 / R10: control fields and power equation
      wr_ctl(1'b0, 4'b0101, 4'b0001, 1'b1);
      chk("R2 range held before edge", {28'h0, rng_o}, 32'hF);
      chk("R9 inhibit pending has no effect", {28'h0, ch_on_o}, 32'h0);
      pulse_fall();
      chk("R3 range transferred", {28'h0, rng_o}, 32'h5);
      chk("R9 inhibit on, pin low", {28'h0, ch_on_o}, 32'h1);
      @(negedge clk); hw_act_pin = 1'b1;
      @(negedge clk);
      chk("R10 pin after one edge", {28'h0, ch_on_o}, 32'h1);
      @(negedge clk);
      chk("R10 pin after two edges", {28'h0, ch_on_o}, 32'hF);
      wr_ctl(1'b0, 4'b0101, 4'b0001, 1'b0);
      chk("R9 pending activate ignored", {28'h0, ch_on_o}, 32'hF);
      pulse_fall();
      chk("R9 latched activate cleared", {28'h0, ch_on_o}, 32'h1);
      wr_ctl(1'b0, 4'b0101, 4'b0001, 1'b1);
      pulse_fall();
      chk("R9 latched activate set", {28'h0, ch_on_o}, 32'hF);

      // R4: write and transfer in the same cycle
      wr_dac(2'd3, 8'h33, 1'b0);
      exp_live[3] = 8'h33;
      wr_dac(2'd2, 8'hAA, 1'b1);
      chk("R4 collision takes pre-write contents", code_o, live_bus());
      pulse_fall();
      exp_live[2] = 8'hAA;
      chk("R4 held word released on next edge", code_o, live_bus());

      // R8: strobe while enable level low is discarded
      en_lvl = 1'b0;
      wr_dac(2'd0, 8'h77, 1'b0);
      en_lvl = 1'b1;
      chk("R8 discarded write, live", code_o, live_bus());
      pulse_fall();
      chk("R8 discarded write, after edge", code_o, live_bus());

      // R5 / R6 / R7: switch to single-buffered mode
      wr_dac(2'd1, 8'h5A, 1'b0);
      wr_ctl(1'b1, 4'b0101, 4'b0001, 1'b1);
      chk("R5 mode set immediately", {31'h0, mode_o}, 32'h1);
      pulse_fall();
      chk("R6 edge ignored in single mode", code_o, live_bus());
      wr_dac(2'd0, 8'hC3, 1'b0);
      exp_live[0] = 8'hC3;
      chk("R6 direct code write", code_o, live_bus());
      wr_ctl(1'b0, 4'b0011, 4'b1000, 1'b1);
      chk("R7 mode stays set", {31'h0, mode_o}, 32'h1);
      chk("R6 direct range write", {28'h0, rng_o}, 32'h3);
      chk("R6 direct power fields, act on", {28'h0, ch_on_o}, 32'hF);
      wr_ctl(1'b0, 4'b0011, 4'b1000, 1'b0);
      chk("R6 direct power fields, act off", {28'h0, ch_on_o}, 32'h8);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule